// File: doc/BRIEF.md
# Integer ALU with Flag Register and Branch Condition Evaluator

This block is the execute-stage arithmetic unit of a small 32-bit in-order core. It combines two operands with one of four operations chosen by a 2-bit function code: add, subtract, bitwise AND or bitwise XOR. The result is combinational and appears on `result_o` in the same cycle as the operands. The same add path also serves address and stack-pointer arithmetic. That use is steered by control outside the block, and it leaves the flags alone because the flag-write strobe stays low.

A three-bit flag register holds zero, negative and signed-overflow. It is loaded from the current result on a rising clock edge, but only while `set_flags_i` is high. Decode raises that strobe for the arithmetic/logical instruction group only.

A condition evaluator reads the registered flags, never the flags of the operation in flight. It decodes a 4-bit condition code into a single taken/true bit, which serves both conditional jumps and conditional moves.

Top module: `alu_cc_unit`

## Requirements
- R1: With `fn_i` = 0, `result_o` equals `a_i + b_i` modulo 2^DATA_W, in the same cycle.
- R2: With `fn_i` = 1, `result_o` equals `b_i - a_i` (second operand minus first) modulo 2^DATA_W.
- R3: With `fn_i` = 2, `result_o` is `a_i & b_i`. With `fn_i` = 3, it is `a_i ^ b_i`.
- R4: On a rising clock edge with `set_flags_i` high, `zf_o` takes (result == 0) and `sf_o` takes the result's most significant bit.
- R5: On such an edge with `fn_i` = 0, `of_o` is set when `a_i` and `b_i` have equal signs and the result sign differs from them. Otherwise it is cleared.
- R6: On such an edge with `fn_i` = 1, `of_o` is set when `a_i` and `b_i` differ in sign and the result sign differs from that of `b_i`. With `fn_i` = 2 or 3, `of_o` is cleared.
- R7: On an edge with `set_flags_i` low, all three flags keep their values, whatever the operands and function code.
- R8: While `rst_ni` is low (asynchronous, active low), `zf_o` = 1, `sf_o` = 0 and `of_o` = 0.
- R9: `cond_true_o` is decoded from the registered flags and `cond_fn_i`: 0 always true; 1 (SF^OF)|ZF; 2 SF^OF; 3 ZF; 4 !ZF; 5 !(SF^OF); 6 !(SF^OF)&!ZF.
- R10: For `cond_fn_i` values 7 to 15, `cond_true_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | DATA_W | First operand (rA side) |
| b_i | input | DATA_W | Second operand (rB side) |
| fn_i | input | 2 | Operation: 0 add, 1 sub, 2 and, 3 xor |
| set_flags_i | input | 1 | Load flag register on this edge |
| cond_fn_i | input | 4 | Condition code to evaluate |
| result_o | output | DATA_W | Operation result |
| zf_o | output | 1 | Registered zero flag |
| sf_o | output | 1 | Registered negative flag |
| of_o | output | 1 | Registered signed-overflow flag |
| cond_true_o | output | 1 | Selected condition holds |

## Verification
The bench subtracts with operands of opposite sign near the most negative value, in both orders. A unit that computed A minus B, or took the overflow sign test from the wrong operand, reports a different result and the wrong overflow. It adds two large positives to reach the sign boundary, then runs AND/XOR straight after an overflowing operation: a design that only set OF, or never cleared it on logical operations, leaves a stale flag. It issues operations with the strobe low, to catch a register that loads on every cycle. It walks every condition code, including the unused values 7 to 15, against flag patterns that separate "less" from "less or equal" and "greater" from "greater or equal". A swapped decode or a missing default shows up there as a wrong condition bit.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_SUB = 2'd1,
    FN_AND = 2'd2,
    FN_XOR = 2'd3
  } alu_fn_e;

  typedef enum logic [3:0] {
    CF_ALWAYS = 4'd0,
    CF_LE     = 4'd1,
    CF_LT     = 4'd2,
    CF_EQ     = 4'd3,
    CF_NE     = 4'd4,
    CF_GE     = 4'd5,
    CF_GT     = 4'd6
  } cond_fn_e;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } flags_t;

  localparam flags_t FLAGS_RST = '{zf: 1'b1, sf: 1'b0, of: 1'b0};

endpackage

// File: rtl/alu_cc_datapath.sv
module alu_cc_datapath
  import alu_cc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        fn_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            flags_nxt_o
);

  localparam int unsigned MSB = DATA_W - 1;

  alu_fn_e fn;
  logic    ovf;

  assign fn = alu_fn_e'(fn_i);

  always_comb begin
    unique case (fn)
      FN_ADD:  res_o = b_i + a_i;
      FN_SUB:  res_o = b_i - a_i;
      FN_AND:  res_o = b_i & a_i;
      default: res_o = b_i ^ a_i;
    endcase
  end

  // signed overflow from operand and result signs
  always_comb begin
    unique case (fn)
      FN_ADD:  ovf = (a_i[MSB] == b_i[MSB]) && (res_o[MSB] != a_i[MSB]);
      FN_SUB:  ovf = (a_i[MSB] != b_i[MSB]) && (res_o[MSB] != b_i[MSB]);
      default: ovf = 1'b0;
    endcase
  end

  assign flags_nxt_o.zf = (res_o == '0);
  assign flags_nxt_o.sf = res_o[MSB];
  assign flags_nxt_o.of = ovf;

endmodule

// File: rtl/alu_cc_flag_reg.sv
module alu_cc_flag_reg
  import alu_cc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  flags_t flags_i,
  output flags_t flags_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flags_o <= FLAGS_RST;
    else if (load_i) flags_o <= flags_i;
  end

endmodule

// File: rtl/alu_cc_cond_eval.sv
module alu_cc_cond_eval
  import alu_cc_pkg::*;
(
  input  flags_t     flags_i,
  input  logic [3:0] cond_fn_i,
  output logic       true_o
);

  logic lt;

  assign lt = flags_i.sf ^ flags_i.of;

  always_comb begin
    unique case (cond_fn_i)
      CF_ALWAYS: true_o = 1'b1;
      CF_LE:     true_o = lt | flags_i.zf;
      CF_LT:     true_o = lt;
      CF_EQ:     true_o = flags_i.zf;
      CF_NE:     true_o = !flags_i.zf;
      CF_GE:     true_o = !lt;
      CF_GT:     true_o = !lt && !flags_i.zf;
      default:   true_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
  import alu_cc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        fn_i,
  input  logic              set_flags_i,
  input  logic [3:0]        cond_fn_i,
  output logic [DATA_W-1:0] result_o,
  output logic              zf_o,
  output logic              sf_o,
  output logic              of_o,
  output logic              cond_true_o
);

  flags_t flags_nxt;
  flags_t flags_q;

  alu_cc_datapath #(.DATA_W(DATA_W)) i_datapath (
    .a_i         (a_i),
    .b_i         (b_i),
    .fn_i        (fn_i),
    .res_o       (result_o),
    .flags_nxt_o (flags_nxt)
  );

  alu_cc_flag_reg i_flag_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (set_flags_i),
    .flags_i (flags_nxt),
    .flags_o (flags_q)
  );

  alu_cc_cond_eval i_cond_eval (
    .flags_i   (flags_q),
    .cond_fn_i (cond_fn_i),
    .true_o    (cond_true_o)
  );

  assign zf_o = flags_q.zf;
  assign sf_o = flags_q.sf;
  assign of_o = flags_q.of;

endmodule

// File: rtl/alu_cc_unit_chk.sv
module alu_cc_unit_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [1:0]        fn_i,
  input logic              set_flags_i,
  input logic [3:0]        cond_fn_i,
  input logic [DATA_W-1:0] result_o,
  input logic              zf_o,
  input logic              sf_o,
  input logic              of_o,
  input logic              cond_true_o
);

  localparam int unsigned MSB = DATA_W - 1;

  AST_RESET_FLAGS: assert property (@(posedge clk_i)
    !rst_ni |-> (zf_o && !sf_o && !of_o)); // R8

  AST_SUB_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn_i == 2'd1) |-> (result_o + a_i == b_i)); // R2

  AST_ZF_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_flags_i |=> (zf_o == ($past(result_o) == '0))); // R4

  AST_SF_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_flags_i |=> (sf_o == $past(result_o[MSB]))); // R4

  AST_ADD_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_flags_i && fn_i == 2'd0 && a_i[MSB] == b_i[MSB] && result_o[MSB] != a_i[MSB])
      |=> of_o); // R5

  AST_LOGIC_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_flags_i && fn_i[1]) |=> !of_o); // R6

  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_flags_i |=> $stable({zf_o, sf_o, of_o})); // R7

  AST_COND_ALWAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_fn_i == 4'd0) |-> cond_true_o); // R9

  AST_COND_UNUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_fn_i > 4'd6) |-> !cond_true_o); // R10

endmodule

bind alu_cc_unit alu_cc_unit_chk #(.DATA_W(DATA_W)) i_alu_cc_unit_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .a_i         (a_i),
  .b_i         (b_i),
  .fn_i        (fn_i),
  .set_flags_i (set_flags_i),
  .cond_fn_i   (cond_fn_i),
  .result_o    (result_o),
  .zf_o        (zf_o),
  .sf_o        (sf_o),
  .of_o        (of_o),
  .cond_true_o (cond_true_o)
);

// File: tb/test_alu_cc_unit.sv
module test_alu_cc_unit;

  localparam int unsigned W = 32;

  typedef struct {
    logic [W-1:0] res;
    logic         zf, sf, of, ct;
    string        rtag, ftag, ctag;
  } item_t;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b1;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [1:0]   fn_i = '0;
  logic         set_flags_i = 1'b0;
  logic [3:0]   cond_fn_i = '0;
  logic [W-1:0] result_o;
  logic         zf_o, sf_o, of_o, cond_true_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  item_t q[$];
  logic mzf = 1'b1, msf = 1'b0, mof = 1'b0;

  always #5 clk_i = ~clk_i;

  alu_cc_unit #(.DATA_W(W)) i_alu_cc_unit (
    .clk_i, .rst_ni, .a_i, .b_i, .fn_i, .set_flags_i, .cond_fn_i,
    .result_o, .zf_o, .sf_o, .of_o, .cond_true_o
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic cond_model(input logic [3:0] c, input logic z, input logic s, input logic o);
    case (c)
      4'd0: return 1'b1;
      4'd1: return (s ^ o) | z;
      4'd2: return s ^ o;
      4'd3: return z;
      4'd4: return !z;
      4'd5: return !(s ^ o);
      4'd6: return !(s ^ o) && !z;
      default: return 1'b0;
    endcase
  endfunction

  // driver: one operation per cycle, expected values pushed to the scoreboard
  task automatic op(input logic [1:0] fn, input logic [W-1:0] a, input logic [W-1:0] b,
                    input bit setf, input logic [3:0] cf);
    item_t it;
    longint sa, sb, wide;
    logic [W-1:0] r;
    @(negedge clk_i);
    a_i = a; b_i = b; fn_i = fn; set_flags_i = setf; cond_fn_i = cf;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    case (fn)
      2'd0: begin wide = sb + sa; r = b + a; it.rtag = "R1"; end
      2'd1: begin wide = sb - sa; r = b - a; it.rtag = "R2"; end
      2'd2: begin wide = 0; r = a & b; it.rtag = "R3"; end
      default: begin wide = 0; r = a ^ b; it.rtag = "R3"; end
    endcase
    if (setf) begin
      mzf = (r == 0);
      msf = r[W-1];
      mof = (fn[1] == 1'b0) && (wide > 64'sd2147483647 || wide < -64'sd2147483648);
      it.ftag = (fn == 2'd0) ? "R4/R5" : "R4/R6";
    end else begin
      it.ftag = "R7";
    end
    it.res = r; it.zf = mzf; it.sf = msf; it.of = mof;
    it.ct = cond_model(cf, mzf, msf, mof);
    it.ctag = (cf > 4'd6) ? "R10" : "R9";
    q.push_back(it);
  endtask

  // monitor: result mid low phase, flags and condition just after the edge
  initial begin
    forever begin
      @(negedge clk_i);
      #2;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk(result_o === it.res, it.rtag, result_o, it.res);
        @(posedge clk_i);
        #1;
        chk({zf_o, sf_o, of_o} === {it.zf, it.sf, it.of}, it.ftag,
            W'({zf_o, sf_o, of_o}), W'({it.zf, it.sf, it.of}));
        chk(cond_true_o === it.ct, it.ctag, W'(cond_true_o), W'(it.ct));
      end
    end
  end

  initial begin
    #1 rst_ni = 1'b0;
    cond_fn_i = 4'd3;
    repeat (2) @(posedge clk_i);
    #1;
    chk({zf_o, sf_o, of_o} === 3'b100, "R8", W'({zf_o, sf_o, of_o}), W'(3'b100));
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk(cond_true_o === 1'b1, "R8/R9 eq after reset", W'(cond_true_o), W'(1));

    op(2'd0, 32'd5, 32'd7, 1'b1, 4'd3);                  // R1 plain add, eq false
    op(2'd0, 32'h7fff_ffff, 32'd1, 1'b1, 4'd2);          // R5 overflow, lt false
    op(2'd0, 32'h7fff_ffff, 32'd1, 1'b1, 4'd1);          // R9 le false
    op(2'd2, 32'h0000_f0f0, 32'h0000_0ff0, 1'b1, 4'd5);  // R6 and clears OF
    op(2'd0, 32'hffff_ffff, 32'd1, 1'b1, 4'd3);          // R5 mixed signs, zero
    op(2'd1, 32'd3, 32'd10, 1'b1, 4'd6);                 // R2 b-a, gt
    op(2'd1, 32'd10, 32'd3, 1'b1, 4'd2);                 // R2 negative, lt
    op(2'd1, 32'd10, 32'd3, 1'b1, 4'd5);                 // R9 ge false
    op(2'd1, 32'd1, 32'h8000_0000, 1'b1, 4'd2);          // R6 overflow, lt true
    op(2'd1, 32'h8000_0000, 32'd1, 1'b1, 4'd5);          // R6 overflow, ge true
    op(2'd3, 32'h1234_5678, 32'h1234_5678, 1'b1, 4'd4);  // R3 xor zero, OF cleared
    op(2'd0, 32'h7fff_ffff, 32'h7fff_ffff, 1'b0, 4'd3);  // R7 hold, eq still true
    op(2'd1, 32'd1, 32'd0, 1'b0, 4'd1);                  // R7 hold, le
    op(2'd1, 32'd7, 32'd7, 1'b1, 4'd6);                  // R9 zero, gt false
    op(2'd1, 32'd7, 32'd7, 1'b1, 4'd1);                  // R9 le true on ZF
    for (int c = 7; c < 16; c++)
      op(2'd2, 32'd0, 32'd0, 1'b0, 4'(c));               // R10 unused codes
    op(2'd0, 32'd0, 32'd0, 1'b0, 4'd0);                  // R9 always
    op(2'd3, 32'hdead_beef, 32'h0f0f_0f0f, 1'b1, 4'd4);  // R3 xor nonzero, ne

    while (q.size() > 0) @(posedge clk_i);
    repeat (3) @(posedge clk_i);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule